// File: doc/BRIEF.md
# Decade-Stepped System Clock Generator

This block turns a 2 MHz master clock into a slow processor clock. Sixteen periods are available in a 1-2-5 sequence from 2 us up to 200 ms. A front stage makes three basic rates. One path divides the master by two, one divides it by five, and one divides it by five and then by two. Each rate produces a tick every time the output should toggle. Each basic rate feeds a cascade of divide-by-ten counters, and each counter in the cascade provides the tick stream for the setting three places slower. The output register toggles on the ticks of the chosen setting, so every period has a 50 % duty cycle.

Control-panel buttons choose the setting. Each button is synchronized and edge-detected. The up and down buttons step a requested index that saturates at both ends, and a one-hot LED vector shows that index. A third button toggles a request to pass a separate fast external clock straight to the output.

A small state machine makes every change glitch-free. Its states are RUN, SWAP and EXT:

- **RUN to SWAP:** RUN toggles the output on the selected ticks. It moves to SWAP when the requested index differs from the applied one, or when the external clock is requested.
- **SWAP to RUN or EXT:** SWAP waits until the output is low, or until the tick that brings it low. In that cycle it applies the new index, clears every divider counter and forces the output low. It then enters EXT if the external clock is requested and RUN otherwise.
- **EXT to RUN:** EXT routes the external clock to the output and holds the dividers cleared. It returns to RUN once the request is withdrawn and the external clock is sampled low.

Top module: `decade_clkgen`

## Requirements
- R1: After a synchronous reset, the LED vector is 16'h0001 (index 0), `ext_on` is 0, and `clk_out` is 0.
- R2: At index s (0 is fastest), `clk_out` is high for H(s) master cycles and low for H(s) master cycles. H(s) = {2, 5, 10}[s mod 3] × DEC_RATIO^(s div 3), which gives 2, 5, 10 us ... 200 ms periods for a 2 MHz master when DEC_RATIO is 10.
- R3: Each synchronized rising edge of `btn_up` raises the index by one, up to a maximum of 15. Holding the button acts only once.
- R4: Each synchronized rising edge of `btn_dn` lowers the index by one, down to a minimum of 0. Rising edges of both buttons in the same cycle leave the index unchanged.
- R5: `led` is one-hot, with bit s set for requested index s.
- R6: A new index takes effect only while `clk_out` is low, and the dividers restart at that point. No high or low phase is ever shorter than the smaller of the old and new H.
- R7: A rising edge of `btn_ext` toggles the external request. Once it is applied, `ext_on` is 1 and `clk_out` equals `ext_clk`.
- R8: After the external request is withdrawn, the output stays on `ext_clk` until `ext_clk` is sampled low. It then returns to the divided clock, starting low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up | input | 1 | Panel button, slower setting |
| btn_dn | input | 1 | Panel button, faster setting |
| btn_ext | input | 1 | Panel button, toggles the external clock request |
| ext_clk | input | 1 | Fast external clock routed through in external mode |
| clk_out | output | 1 | System clock output |
| led | output | 16 | One-hot indication of the requested setting |
| ext_on | output | 1 | High while the external clock is routed to the output |

## Verification
The bench uses a decade ratio of two so that all sixteen settings stay short. It walks the index up through every setting and checks that the measured high and low lengths match the computed H. A check of only one phase would miss a duty error, and a walk through only one of the three taps would miss a wrong front divider or a wrong decade cascade.

A phase monitor watches every transition, including the ones where the setting changes in mid-cycle. It separates a switch that waits for a low output from one that cuts a phase short. The bench also does the following:

- presses a button again at each end of the range, to catch a missing saturation;
- presses both buttons in the same cycle;
- holds a button for several cycles, to detect repeated stepping;
- drives the external clock both high and low, in and out of external mode, to show that the routing and the exit condition wait on the external level.

// File: rtl/decade_clkgen_pkg.sv
package decade_clkgen_pkg;

    // Controller states of the output selector
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,   // divided clock toggling on selected ticks
        ST_SWAP = 2'd1,   // change pending, waiting for a low output
        ST_EXT  = 2'd2    // external clock routed to the output
    } clkgen_state_e;

endpackage

// File: rtl/clkgen_btn_edge.sv
module clkgen_btn_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;

    // One pulse per press: a rise is never followed directly by another rise
    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
                rise[i] |=> !rise[i]) else $error("button pulse repeated"); // R3
        end
    endgenerate
endmodule

// File: rtl/clkgen_tick_chain.sv
module clkgen_tick_chain #(
    parameter int NSET      = 16,
    parameter int DEC_RATIO = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    output logic [NSET-1:0] tick
);
    localparam int DW = (DEC_RATIO > 2) ? $clog2(DEC_RATIO) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DEC_RATIO - 1);

    logic       cnt2_q;
    logic [2:0] cnt5_q;
    logic       half_q;

    // Front prescaler: /2, /5 and /5 followed by /2 tick streams
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt2_q <= 1'b0;
            cnt5_q <= 3'd0;
            half_q <= 1'b0;
        end else begin
            cnt2_q <= ~cnt2_q;
            cnt5_q <= (cnt5_q == 3'd4) ? 3'd0 : cnt5_q + 3'd1;
            if (cnt5_q == 3'd4)
                half_q <= ~half_q;
        end
    end

    assign tick[0] = cnt2_q;
    assign tick[1] = (cnt5_q == 3'd4);
    assign tick[2] = (cnt5_q == 3'd4) && half_q;

    // Each decade stage slows the stream three settings below it
    generate
        for (genvar s = 3; s < NSET; s++) begin : g_dec
            logic [DW-1:0] dcnt_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    dcnt_q <= '0;
                else if (tick[s-3])
                    dcnt_q <= (dcnt_q == DLAST) ? '0 : dcnt_q + DW'(1);
            end
            assign tick[s] = tick[s-3] && (dcnt_q == DLAST);

            AST_DEC_RANGE: assert property (@(posedge clk) disable iff (rst)
                dcnt_q <= DLAST) else $error("decade counter out of range"); // R2
        end
    endgenerate

    AST_DIV5_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt5_q <= 3'd4) else $error("divide-by-five out of range"); // R2
    AST_TICK2_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick[0] |=> !tick[0]) else $error("fastest tick back to back"); // R2
endmodule

// File: rtl/decade_clkgen.sv
module decade_clkgen
    import decade_clkgen_pkg::*;
#(
    parameter int NSET      = 16,
    parameter int DEC_RATIO = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            btn_up,
    input  logic            btn_dn,
    input  logic            btn_ext,
    input  logic            ext_clk,
    output logic            clk_out,
    output logic [NSET-1:0] led,
    output logic            ext_on
);
    localparam int SW = $clog2(NSET);
    localparam logic [SW-1:0] IDX_TOP = SW'(NSET - 1);

    clkgen_state_e state_q, state_d;
    logic [SW-1:0] req_q, sel_q;
    logic          ext_req_q, div_q;
    logic [2:0]    press;
    logic          up_p, dn_p, ext_p;
    logic [NSET-1:0] tick;
    logic          apply, clr, tgl, fall;

    clkgen_btn_edge #(.N(3)) u_btn (
        .clk (clk),
        .rst (rst),
        .raw ({btn_ext, btn_dn, btn_up}),
        .rise(press)
    );
    assign up_p  = press[0];
    assign dn_p  = press[1];
    assign ext_p = press[2];

    clkgen_tick_chain #(.NSET(NSET), .DEC_RATIO(DEC_RATIO)) u_chain (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .tick(tick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // Next state and control strobes
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        clr     = 1'b0;
        tgl     = 1'b0;
        fall    = div_q && tick[sel_q];
        unique case (state_q)
            ST_RUN: begin
                tgl = tick[sel_q];
                if (req_q != sel_q || ext_req_q)
                    state_d = ST_SWAP;
            end
            ST_SWAP: begin
                if (!div_q || fall) begin
                    apply   = 1'b1;
                    clr     = 1'b1;
                    state_d = ext_req_q ? ST_EXT : ST_RUN;
                end
            end
            ST_EXT: begin
                clr = 1'b1;
                if (!ext_req_q && !ext_clk) begin
                    apply   = 1'b1;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Selector, request and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            sel_q     <= '0;
            ext_req_q <= 1'b0;
            div_q     <= 1'b0;
        end else begin
            if (up_p && !dn_p && req_q != IDX_TOP)
                req_q <= req_q + SW'(1);
            else if (dn_p && !up_p && req_q != '0)
                req_q <= req_q - SW'(1);
            if (ext_p)
                ext_req_q <= ~ext_req_q;
            if (apply)
                sel_q <= req_q;
            if (apply || state_q == ST_EXT)
                div_q <= 1'b0;
            else if (tgl)
                div_q <= ~div_q;
        end
    end

    assign ext_on  = (state_q == ST_EXT);
    assign clk_out = ext_on ? ext_clk : div_q;
    assign led     = NSET'(1) << req_q;

    AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(led) == 1) else $error("led not one-hot"); // R5
    AST_UP_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (req_q == IDX_TOP && up_p) |=> req_q == IDX_TOP) else $error("up wrapped"); // R3
    AST_DN_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (req_q == '0 && dn_p) |=> req_q == '0) else $error("down wrapped"); // R4
    AST_SWAP_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> !div_q) else $error("setting changed while high"); // R6
    AST_RISE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> $past(state_q) == ST_RUN) else $error("rise outside run"); // R6
    AST_EXT_DIV_IDLE: assert property (@(posedge clk) disable iff (rst)
        ext_on |-> !div_q) else $error("divider active in external mode"); // R7
    AST_EXT_EXIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_on) |-> !$past(ext_clk)) else $error("left external mode while high"); // R8
endmodule

// File: tb/decade_clkgen_bench.sv
module decade_clkgen_bench;
    localparam int NSET = 16;
    localparam int R    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_up = 1'b0, btn_dn = 1'b0, btn_ext = 1'b0, ext_clk = 1'b0;
    logic clk_out, ext_on;
    logic [NSET-1:0] led;

    int checks = 0;
    int fails  = 0;
    int min_h  = 1;
    bit mon_en = 1'b0;

    always #4 clk = ~clk;

    decade_clkgen #(.NSET(NSET), .DEC_RATIO(R)) u_decade_clkgen (
        .clk(clk), .rst(rst), .btn_up(btn_up), .btn_dn(btn_dn),
        .btn_ext(btn_ext), .ext_clk(ext_clk), .clk_out(clk_out),
        .led(led), .ext_on(ext_on)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int hexp(input int s);
        int b = (s % 3 == 0) ? 2 : (s % 3 == 1) ? 5 : 10;
        for (int k = 0; k < s / 3; k++) b *= R;
        return b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic press(input bit up, input bit dn, input bit ex);
        @(negedge clk);
        btn_up = up; btn_dn = dn; btn_ext = ex;
        repeat (6) @(negedge clk);
        btn_up = 1'b0; btn_dn = 1'b0; btn_ext = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev;
        do begin
            prev = clk_out;
            @(negedge clk);
        end while (!(!prev && clk_out));
        hi = 0;
        while (clk_out) begin hi++; @(negedge clk); end
        lo = 0;
        while (!clk_out) begin lo++; @(negedge clk); end
    endtask

    // Phase monitor for glitch-free switching
    int   run_len = 0;
    logic last_v  = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
            last_v  = 1'b0;
        end else if (clk_out !== last_v) begin
            if (mon_en && !ext_on && run_len > 0)
                chk(run_len >= min_h, "R6 phase length", run_len, min_h);
            run_len = 1;
            last_v  = clk_out;
        end else begin
            run_len++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo, idx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(led == 16'h0001, "R1 led", led, 16'h0001);
        chk(ext_on == 1'b0, "R1 ext_on", ext_on, 0);
        chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);

        // R2 fastest setting
        measure(hi, lo);
        chk(hi == hexp(0), "R2 high s0", hi, hexp(0));
        chk(lo == hexp(0), "R2 low s0", lo, hexp(0));
        mon_en = 1'b1;

        // R2/R3/R5 up sweep across all settings
        idx = 0;
        for (int s = 1; s < NSET; s++) begin
            min_h = imin(hexp(idx), hexp(s));
            press(1'b1, 1'b0, 1'b0);
            idx = s;
            chk(led == (NSET'(1) << s), "R3 R5 led after up", led, NSET'(1) << s);
            measure(hi, lo);
            measure(hi, lo);
            chk(hi == hexp(s), "R2 high", hi, hexp(s));
            chk(lo == hexp(s), "R2 low", lo, hexp(s));
            min_h = hexp(s);
        end
        // R3 saturation at slowest
        press(1'b1, 1'b0, 1'b0);
        chk(led == 16'h8000, "R3 saturate top", led, 16'h8000);

        // R4 down sweep
        for (int s = NSET - 2; s >= 0; s--) begin
            min_h = imin(hexp(idx), hexp(s));
            press(1'b0, 1'b1, 1'b0);
            idx = s;
            chk(led == (NSET'(1) << s), "R4 R5 led after down", led, NSET'(1) << s);
        end
        repeat (4 * hexp(NSET - 1)) @(negedge clk);
        min_h = hexp(0);
        press(1'b0, 1'b1, 1'b0);
        chk(led == 16'h0001, "R4 saturate bottom", led, 16'h0001);
        measure(hi, lo);
        measure(hi, lo);
        chk(hi == hexp(0) && lo == hexp(0), "R2 back at s0", hi, hexp(0));

        // R4 simultaneous presses
        min_h = imin(hexp(0), hexp(1));
        press(1'b1, 1'b0, 1'b0);
        press(1'b1, 1'b1, 1'b0);
        chk(led == 16'h0002, "R4 both buttons", led, 16'h0002);
        measure(hi, lo);
        measure(hi, lo);
        chk(hi == hexp(1) && lo == hexp(1), "R2 setting 1", hi, hexp(1));

        // R7 external routing
        mon_en = 1'b0;
        ext_clk = 1'b0;
        press(1'b0, 1'b0, 1'b1);
        repeat (2 * hexp(1) + 4) @(negedge clk);
        chk(ext_on == 1'b1, "R7 ext_on", ext_on, 1);
        ext_clk = 1'b1; #1;
        chk(clk_out == 1'b1, "R7 follows high", clk_out, 1);
        @(negedge clk);
        ext_clk = 1'b0; #1;
        chk(clk_out == 1'b0, "R7 follows low", clk_out, 0);
        @(negedge clk);

        // R8 exit waits for a low external clock
        ext_clk = 1'b1;
        press(1'b0, 1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk(ext_on == 1'b1, "R8 held while ext high", ext_on, 1);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        chk(ext_on == 1'b0, "R8 ext_on cleared", ext_on, 0);
        chk(clk_out == 1'b0, "R8 resumes low", clk_out, 0);
        measure(hi, lo);
        chk(hi == hexp(1) && lo == hexp(1), "R8 divided clock resumes", hi, hexp(1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule